// File: doc/BRIEF.md
# Parity-Framed Asynchronous Serial Transmitter

This block turns one parallel byte into an 11-bit asynchronous serial frame on a single line. The frame starts with a low start bit. Eight data bits follow, least significant first, then a parity bit and a high stop bit. The block runs from a master clock at sixteen times the bit rate, and a divide-by-16 inside the block sets the length of each bit.

The parallel side uses a write strobe with a ready flag, in place of a valid/ready pair. The strobe `wr_n` is active low, and only its falling edge counts. A byte is accepted only on a falling edge of `wr_n` that finds `tx_ready` high.

The back-pressure rules are simple. While `tx_ready` is low, a falling edge is dropped: it is neither held nor replayed later. The writer must release the strobe and then pull it low again once ready has returned.

A static mode input selects even or odd parity. The block keeps no FIFO, and it has separate input and output ports rather than a shared bus.

Top module: `uart_par_tx`

## Requirements
- R1: A frame has 11 bit periods in this order: start bit (0), data bits 0 through 7 (least significant bit first), parity bit, stop bit (1). For the byte 0xAA with even parity, the line carries 0,0,1,0,1,0,1,0,1,0,1.
- R2: Each bit period lasts exactly 16 master-clock cycles.
- R3: `tx_line` is 1 during reset and whenever no frame is in progress.
- R4: When `odd_par` is 0, the 8 data bits and the parity bit together hold an even number of ones.
- R5: When `odd_par` is 1, the 8 data bits and the parity bit together hold an odd number of ones. For 0xAA, the last two bits are 1,1.
- R6: A write is accepted at the clock edge where `wr_n` is 0, `wr_n` was 1 at the previous edge, and `tx_ready` is 1. The start bit appears on `tx_line` right after that edge.
- R7: `tx_ready` drops right after an accepted write and stays low for exactly 176 cycles. It is high exactly when the block is idle.
- R8: A falling edge of `wr_n` while `tx_ready` is 0 is ignored. It does not change the frame in progress, and no frame follows from it, even if `wr_n` is still held low when ready returns.
- R9: Holding `wr_n` low for many cycles loads the byte only once.
- R10: Reset is synchronous and active high. It aborts any frame and leaves the block idle, with `tx_ready` at 1 and `tx_line` at 1.
- R11: The byte and the parity mode are captured at the accepted write. Changes to `wr_byte` or `odd_par` during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x16 | input | 1 | Master clock at 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; acted on at its falling edge |
| wr_byte | input | 8 | Byte to transmit |
| odd_par | input | 1 | Parity mode: 0 even, 1 odd |
| tx_line | output | 1 | Serial output, high when idle |
| tx_ready | output | 1 | High when a new byte may be written |

## Verification
The hardest case to reach from the ports is a strobe that is held low across the moment ready comes back. It must not start a new frame.

The stimulus produces this case in two ways. In the first, it pulls the strobe low in the middle of a frame and keeps it low until well after ready rises. In the second, it holds a single accepted strobe low for longer than a full frame.

A behavioural reference model is compared against the outputs on every cycle. It checks that the frame in progress is unchanged, and that the line stays idle afterwards. Mid-frame resets and changes to the byte and the mode during a frame are also applied.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;

  localparam logic LINE_MARK  = 1'b1;
  localparam logic LINE_SPACE = 1'b0;
endpackage

// File: rtl/wr_edge_det.sv
module wr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall_pulse
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b1;
    else     strobe_q <= strobe_n;
  end

  assign fall_pulse = strobe_q & ~strobe_n;

  // R9
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/bit_tick_div.sv
module bit_tick_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (run)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  par_mode_e         mode,
  input  logic              tick,
  output logic              line,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [IW-1:0]      bits_left;
  logic               par_bit;

  assign par_bit = (^data) ^ (mode == PAR_ODD);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '1;
      bits_left <= '0;
      busy      <= 1'b0;
    end else if (load) begin
      shreg     <= {LINE_MARK, par_bit, data, LINE_SPACE};
      bits_left <= IW'(FRAME_W - 1);
      busy      <= 1'b1;
    end else if (busy && tick) begin
      if (bits_left == '0) begin
        busy <= 1'b0;
      end else begin
        shreg     <= {LINE_MARK, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  assign line = shreg[0];

  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);
  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !load) |=> $stable(line));
  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && !line));
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_x16,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              odd_par,
  output logic              tx_line,
  output logic              tx_ready
);
  logic wr_fall;
  logic accept;
  logic busy;
  logic bit_tick;

  wr_edge_det u_edge (
    .clk        (clk_x16),
    .rst        (rst),
    .strobe_n   (wr_n),
    .fall_pulse (wr_fall)
  );

  assign accept = wr_fall && !busy;

  bit_tick_div #(.DIV(OVERSAMPLE)) u_div (
    .clk     (clk_x16),
    .rst     (rst),
    .restart (accept),
    .run     (busy),
    .tick    (bit_tick)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk  (clk_x16),
    .rst  (rst),
    .load (accept),
    .data (wr_byte),
    .mode (par_mode_e'(odd_par)),
    .tick (bit_tick),
    .line (tx_line),
    .busy (busy)
  );

  assign tx_ready = !busy;

  // R7
  ready_drop_cause_chk: assert property (@(posedge clk_x16) disable iff (rst)
    $fell(tx_ready) |-> $past(wr_fall));
  // R8
  ignored_strobe_chk: assert property (@(posedge clk_x16) disable iff (rst)
    (wr_fall && !tx_ready && !bit_tick) |=> ($stable(tx_line) && !tx_ready));
  // R3
  ready_line_idle_chk: assert property (@(posedge clk_x16) disable iff (rst)
    $rose(tx_ready) |-> tx_line);
endmodule

// File: tb/uart_par_tx_tb_top.sv
module uart_par_tx_tb_top;
  localparam int DW = 8;
  localparam int OS = 16;
  localparam int FW = DW + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_n = 1'b1;
  logic          odd_par = 1'b0;
  logic [DW-1:0] wr_byte = '0;
  logic          tx_line;
  logic          tx_ready;

  always #2 clk = ~clk;

  uart_par_tx #(.DATA_W(DW), .OVERSAMPLE(OS)) dut_i (
    .clk_x16 (clk),
    .rst     (rst),
    .wr_n    (wr_n),
    .wr_byte (wr_byte),
    .odd_par (odd_par),
    .tx_line (tx_line),
    .tx_ready(tx_ready)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R3";

  // reference model state
  bit m_busy = 0;
  bit m_prev = 1;
  int m_idx = 0;
  int m_cnt = 0;
  bit m_bits[FW];
  bit exp_line = 1;
  bit exp_ready = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
      m_prev = 1;
    end else begin
      if (!m_busy && m_prev && !wr_n) begin
        m_bits[0] = 0;
        for (int i = 0; i < DW; i++) m_bits[i+1] = wr_byte[i];
        m_bits[DW+1] = (^wr_byte) ^ odd_par;
        m_bits[DW+2] = 1;
        m_busy = 1;
        m_idx = 0;
        m_cnt = 0;
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == OS) begin
          m_cnt = 0;
          m_idx++;
          if (m_idx == FW) m_busy = 0;
        end
      end
      m_prev = wr_n;
    end
    exp_line  = m_busy ? m_bits[m_idx] : 1'b1;
    exp_ready = !m_busy;
  end

  task automatic chk(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, tx_line, exp_line, "model tx_line");
      chk(cur_req, tx_ready, exp_ready, "model tx_ready");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // send one byte and sample every bit in the middle of its period
  task automatic send_capture(logic [7:0] b, bit odd, string req);
    bit expv[FW];
    expv[0] = 0;
    for (int i = 0; i < DW; i++) expv[i+1] = b[i];
    expv[DW+1] = (^b) ^ odd;
    expv[DW+2] = 1;
    @(negedge clk);
    wr_byte = b; odd_par = odd; wr_n = 0;
    @(negedge clk);
    wr_n = 1;
    chk("R7", tx_ready, 1'b0, "ready after write");
    repeat (7) @(negedge clk);
    for (int i = 0; i < FW; i++) begin
      chk(req, tx_line, expv[i], $sformatf("bit %0d", i));
      repeat (OS) @(negedge clk);
    end
  endtask

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    // R3 R10: reset state
    chk("R10", tx_ready, 1'b1, "ready in reset");
    chk("R3", tx_line, 1'b1, "line in reset");
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R3", tx_line, 1'b1, "idle line");

    // R1 R4: 0xAA even
    cur_req = "R1";
    send_capture(8'hAA, 0, "R1");
    begin
      bit seq[FW] = '{0,0,1,0,1,0,1,0,1,0,1};
      cur_req = "R4";
      @(negedge clk);
      wr_byte = 8'hAA; odd_par = 0; wr_n = 0;
      @(negedge clk); wr_n = 1;
      repeat (7) @(negedge clk);
      for (int i = 0; i < FW; i++) begin
        chk("R4", tx_line, seq[i], $sformatf("0xAA even bit %0d", i));
        repeat (OS) @(negedge clk);
      end
    end
    // R5: 0xAA odd, last two bits 1,1
    cur_req = "R5";
    send_capture(8'hAA, 1, "R5");

    // R2 R7: ready low duration 176 cycles
    cur_req = "R7";
    @(negedge clk);
    wr_byte = 8'h01; odd_par = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    lowcnt = 1;
    while (!tx_ready) begin @(negedge clk); if (!tx_ready) lowcnt++; end
    chk("R7", (lowcnt == 176), 1'b1, $sformatf("ready low %0d cycles", lowcnt));
    chk("R2", (lowcnt == FW * OS), 1'b1, "bit period 16 cycles");

    // R4 R5 R6: varied bytes, back-to-back as soon as ready
    cur_req = "R6";
    send_capture(8'h00, 0, "R4");
    send_capture(8'hFF, 1, "R5");
    send_capture(8'h80, 1, "R5");
    send_capture(8'h7E, 0, "R4");
    send_capture(8'h13, 0, "R6");

    // R8: strobe during frame held across return of ready
    cur_req = "R8";
    @(negedge clk);
    wr_byte = 8'h5A; odd_par = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    repeat (40) @(negedge clk);
    wr_byte = 8'hFF; wr_n = 0;
    while (!tx_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    wr_n = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R8", tx_ready, 1'b1, "no queued frame");
    end
    chk("R8", tx_line, 1'b1, "line idle after ignored strobe");

    // R9: long hold loads once
    cur_req = "R9";
    @(negedge clk);
    wr_byte = 8'hC5; odd_par = 1; wr_n = 0;
    repeat (300) @(negedge clk);
    chk("R9", tx_ready, 1'b1, "single load under long hold");
    chk("R9", tx_line, 1'b1, "line idle under long hold");
    wr_n = 1;
    repeat (3) @(negedge clk);

    // R11: inputs change mid-frame
    cur_req = "R11";
    @(negedge clk);
    wr_byte = 8'h3C; odd_par = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    repeat (20) @(negedge clk);
    wr_byte = 8'hC3; odd_par = 1;
    while (!tx_ready) @(negedge clk);
    repeat (3) @(negedge clk);

    // R10: reset mid-frame
    cur_req = "R10";
    @(negedge clk);
    wr_byte = 8'h96; odd_par = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    repeat (50) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R10", tx_ready, 1'b1, "ready after mid-frame reset");
    chk("R10", tx_line, 1'b1, "line after mid-frame reset");
    rst = 0;
    repeat (20) @(negedge clk);
    chk("R10", tx_line, 1'b1, "idle after reset release");
    cur_req = "R6";
    send_capture(8'h69, 1, "R6");

    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule